// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit timer/counter and a watchdog counter that take turns using one 8-bit prescaler. A control register, written and read through a simple register port, picks the timer's count source (the instruction-cycle tick or edges on an external pin), the pin edge that counts, which function owns the prescaler, and a 3-bit ratio code. The same code gives the timer a ratio of 1:2^(n+1) and the watchdog a ratio of 1:2^n.

The timer raises a one-cycle overflow pulse when it wraps from its top value to zero. The watchdog counts a free-running base tick while its enable is high. It raises a one-cycle timeout pulse when its counter wraps. It keeps counting during sleep, and a watchdog-clear or sleep strobe restarts it. The event that clears the prescaler depends on which function owns it.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the counter reads 0x00 and the control register reads 0xBF.
- R2: Control fields are: bits [2:0] ratio code n, bit 3 prescaler owner (0 timer, 1 watchdog), bit 4 pin edge (0 rising, 1 falling), bit 5 count source (0 instruction tick, 1 pin). A control write reads back unchanged.
- R3: While the timer owns the prescaler, the counter advances once per 2^(n+1) qualifying events, counted from the last prescaler clear.
- R4: While the watchdog owns the prescaler, the counter advances once per qualifying event.
- R5: With source 1, the pin passes through two synchronizer flops and only the selected edge counts. With source 1, instruction ticks have no effect on the counter.
- R6: A counter write loads the written value. When the timer owns the prescaler, the write also clears the prescaler. The write takes priority over a count in the same cycle.
- R7: The overflow output pulses high for exactly one cycle, in the cycle the counter wraps from 0xFF to 0x00.
- R8: Counted from a clear, the first timeout comes after 2^(8+n) enabled base ticks when the watchdog owns the prescaler, and after 2^8 enabled base ticks when the timer owns it. The timeout pulse lasts one cycle.
- R9: Either a watchdog-clear strobe or a sleep strobe restarts the watchdog count. When the watchdog owns the prescaler, the strobe also clears the prescaler.
- R10: While the watchdog enable is low, base ticks are ignored and no timeout occurs. The count resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wr_cnt | input | 1 | Write strobe for the counter |
| wr_ctl | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data |
| cnt_out | output | 8 | Current counter value |
| ctl_out | output | 8 | Current control register |
| wd_tick | input | 1 | Free-running watchdog base tick |
| wd_en | input | 1 | Watchdog enable |
| wd_clr | input | 1 | Watchdog-clear strobe |
| sleep_cmd | input | 1 | Sleep strobe, also clears the watchdog |
| ovf_pulse | output | 1 | Timer overflow pulse |
| wd_timeout | output | 1 | Watchdog timeout pulse |

## Verification
The assertions assume that at least 2^8 base ticks separate two timeouts, which the counter width guarantees. They also assume that strobes are one clock wide and that inputs change only between clock edges. The stimulus drives every input at the falling clock edge. It draws the ratio codes and tick counts from a seeded generator, keeping each run within a few thousand cycles, and holds each pin level for several cycles so that every edge passes through the synchronizer.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int CTL_W     = 8;
    localparam int F_RATIO_W = 3;
    localparam int F_OWNER   = 3;
    localparam int F_EDGE    = 4;
    localparam int F_SRC     = 5;
    localparam logic [CTL_W-1:0] CTL_RESET = 8'hBF;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= pin;
                else chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/tw_ratio_tap.sv
module tw_ratio_tap #(
    parameter int PRE_W   = 8,
    parameter int RATIO_W = 3
) (
    input  logic [PRE_W-1:0]   pre,
    input  logic [RATIO_W-1:0] code,
    output logic               tmr_full,
    output logic               wd_full
);
    localparam logic [PRE_W:0] ONE = (PRE_W+1)'(1);
    logic [PRE_W:0] pow_n;
    logic [PRE_W:0] tmask;
    logic [PRE_W:0] wmask;

    always_comb begin
        pow_n    = ONE << code;
        tmask    = (pow_n << 1) - ONE;
        wmask    = pow_n - ONE;
        tmr_full = &(pre | ~tmask[PRE_W-1:0]);
        wd_full  = &(pre | ~wmask[PRE_W-1:0]);
    end
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer #(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int WD_W   = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wr_cnt,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cnt_out,
    output logic [7:0]        ctl_out,
    input  logic              wd_tick,
    input  logic              wd_en,
    input  logic              wd_clr,
    input  logic              sleep_cmd,
    output logic              ovf_pulse,
    output logic              wd_timeout
);
    import tw_pkg::*;

    localparam int RATIO_W = F_RATIO_W;
    localparam logic [DATA_W-1:0] CNT_MAX = '1;
    localparam logic [WD_W-1:0]   WD_MAX  = '1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DATA_W-1:0] cnt;
        logic [WD_W-1:0]   wdc;
        logic [CTL_W-1:0]  ctl;
        logic              ovf;
        logic              wto;
    } state_t;

    state_t st_q, st_d;

    logic pin_rise, pin_fall;
    logic tmr_full, wd_full;
    logic own_wd, tmr_evt, wd_evt, pre_evt, tmr_step, wd_step, wd_restart;

    tw_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    tw_ratio_tap #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_tap (
        .pre     (st_q.pre),
        .code    (st_q.ctl[RATIO_W-1:0]),
        .tmr_full(tmr_full),
        .wd_full (wd_full)
    );

    always_comb begin
        own_wd     = st_q.ctl[F_OWNER];
        tmr_evt    = st_q.ctl[F_SRC] ? (st_q.ctl[F_EDGE] ? pin_fall : pin_rise) : cyc_tick;
        wd_evt     = wd_tick & wd_en;
        pre_evt    = own_wd ? wd_evt : tmr_evt;
        tmr_step   = tmr_evt & (own_wd | tmr_full);
        wd_step    = wd_evt & (~own_wd | wd_full);
        wd_restart = wd_clr | sleep_cmd;

        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.wto = 1'b0;

        if (pre_evt) st_d.pre = st_q.pre + PRE_W'(1);

        if (wr_ctl) st_d.ctl = wr_data[CTL_W-1:0];

        if (wr_cnt) begin
            st_d.cnt = wr_data;
            if (!own_wd) st_d.pre = '0;
        end else if (tmr_step) begin
            st_d.cnt = st_q.cnt + DATA_W'(1);
            st_d.ovf = (st_q.cnt == CNT_MAX);
        end

        if (wd_restart) begin
            st_d.wdc = '0;
            if (own_wd) st_d.pre = '0;
        end else if (wd_step) begin
            st_d.wdc = st_q.wdc + WD_W'(1);
            st_d.wto = (st_q.wdc == WD_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre <= '0;
            st_q.cnt <= '0;
            st_q.wdc <= '0;
            st_q.ctl <= CTL_RESET;
            st_q.ovf <= 1'b0;
            st_q.wto <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_out    = st_q.cnt;
    assign ctl_out    = st_q.ctl;
    assign ovf_pulse  = st_q.ovf;
    assign wd_timeout = st_q.wto;
endmodule

// File: rtl/shared_prescale_timer_chk.sv
module shared_prescale_timer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_tick,
    input logic              wr_cnt,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cnt_out,
    input logic [7:0]        ctl_out,
    input logic              wd_en,
    input logic              ovf_pulse,
    input logic              wd_timeout
);
    assert_ovf_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt_out == '0));

    assert_ovf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> !wd_timeout);

    assert_no_timeout_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wd_en) |-> !wd_timeout);

    assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_cnt) |-> (cnt_out == $past(wr_data)));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_cnt && !cyc_tick && !ctl_out[5]) |-> $stable(cnt_out));
endmodule

bind shared_prescale_timer shared_prescale_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .wr_cnt    (wr_cnt),
    .wr_data   (wr_data),
    .cnt_out   (cnt_out),
    .ctl_out   (ctl_out),
    .wd_en     (wd_en),
    .ovf_pulse (ovf_pulse),
    .wd_timeout(wd_timeout)
);

// File: tb/tb_shared_prescale_timer.sv
module tb_shared_prescale_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0, ext_pin = 1'b0, wr_cnt = 1'b0, wr_ctl = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt_out, ctl_out;
    logic wd_tick = 1'b0, wd_en = 1'b1, wd_clr = 1'b0, sleep_cmd = 1'b0;
    logic ovf_pulse, wd_timeout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shared_prescale_timer dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wr_data(wr_data),
        .cnt_out(cnt_out), .ctl_out(ctl_out), .wd_tick(wd_tick), .wd_en(wd_en),
        .wd_clr(wd_clr), .sleep_cmd(sleep_cmd), .ovf_pulse(ovf_pulse),
        .wd_timeout(wd_timeout)
    );

    function automatic int tmr_expect(int events, int code);
        return (events >> (code + 1)) % 256;
    endfunction

    function automatic int wd_expect(bit owned, int code);
        return owned ? (256 << code) : 256;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(logic [7:0] v);
        @(negedge clk); wr_ctl = 1'b1; wr_data = v;
        @(negedge clk); wr_ctl = 1'b0;
    endtask

    task automatic write_cnt(logic [7:0] v);
        @(negedge clk); wr_cnt = 1'b1; wr_data = v;
        @(negedge clk); wr_cnt = 1'b0;
    endtask

    task automatic ticks(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); cyc_tick = 1'b1;
            @(negedge clk); cyc_tick = 1'b0;
        end
    endtask

    task automatic pin_level(logic v);
        @(negedge clk); ext_pin = v;
        cyc_tick = 1'b1;
        @(negedge clk); cyc_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wd_strobe(bit use_sleep);
        @(negedge clk);
        if (use_sleep) sleep_cmd = 1'b1; else wd_clr = 1'b1;
        @(negedge clk); sleep_cmd = 1'b0; wd_clr = 1'b0;
    endtask

    // returns the tick index of the first timeout, or 0 if none within limit
    task automatic wd_measure(int limit, output int found);
        found = 0;
        @(negedge clk); wd_tick = 1'b1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (wd_timeout) begin found = i; break; end
        end
        wd_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int r, code, k;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 counter reset", cnt_out, 0);
        check("R1 control reset", ctl_out, 8'hBF);

        write_ctl(8'h15);
        check("R2 control readback", ctl_out, 8'h15);

        // R3 random ratios with timer-owned prescaler
        for (int t = 0; t < 6; t++) begin
            code = $urandom_range(0, 7);
            k = $urandom_range(1, 600);
            write_ctl(8'(code));
            write_cnt(8'h00);
            ticks(k);
            check("R3 prescaled count", cnt_out, tmr_expect(k, code));
        end

        // R4 watchdog-owned prescaler: one step per tick
        write_ctl(8'h0F);
        write_cnt(8'h10);
        ticks(37);
        check("R4 unscaled count", cnt_out, 8'h10 + 37);

        // R5 rising edges, instruction ticks ignored
        write_ctl(8'h28);
        write_cnt(8'h00);
        for (int i = 0; i < 5; i++) begin pin_level(1'b1); pin_level(1'b0); end
        check("R5 rising edges", cnt_out, 5);
        write_ctl(8'h38);
        write_cnt(8'h00);
        for (int i = 0; i < 3; i++) begin pin_level(1'b1); pin_level(1'b0); end
        check("R5 falling edges", cnt_out, 3);
        write_ctl(8'h39);
        write_cnt(8'h00);
        ticks(6);
        check("R5 ticks ignored on pin source", cnt_out, 0);

        // R6 write clears the prescaler (ratio 1:4)
        write_ctl(8'h01);
        write_cnt(8'h00);
        ticks(3);
        write_cnt(8'h09);
        ticks(3);
        check("R6 prescaler cleared by write", cnt_out, 9);
        ticks(1);
        check("R6 step after fourth tick", cnt_out, 10);

        // R7 overflow
        write_ctl(8'h08);
        write_cnt(8'hFE);
        ticks(1);
        check("R7 no pulse before wrap", ovf_pulse, 0);
        @(negedge clk); cyc_tick = 1'b1;
        @(negedge clk); cyc_tick = 1'b0;
        check("R7 pulse on wrap", ovf_pulse, 1);
        check("R7 counter wrapped", cnt_out, 0);
        @(negedge clk);
        check("R7 pulse one cycle", ovf_pulse, 0);

        // R8 watchdog periods
        write_ctl(8'h02);
        wd_strobe(1'b0);
        wd_measure(5000, r);
        check("R8 period timer owns prescaler", r, wd_expect(1'b0, 2));
        check("R8 pulse one cycle", wd_timeout, 0);
        write_ctl(8'h0A);
        wd_strobe(1'b0);
        wd_measure(5000, r);
        check("R8 period code 2", r, wd_expect(1'b1, 2));
        code = $urandom_range(0, 5);
        write_ctl(8'h08 | 8'(code));
        wd_strobe(1'b0);
        wd_measure(20000, r);
        check("R8 period random code", r, wd_expect(1'b1, code));

        // R9 sleep and clear restart the count
        write_ctl(8'h0A);
        wd_strobe(1'b0);
        wd_measure(700, r);
        check("R9 no timeout before restart", r, 0);
        wd_strobe(1'b1);
        wd_measure(5000, r);
        check("R9 full period after sleep", r, 1024);
        wd_measure(700, r);
        check("R9 partial run", r, 0);
        wd_strobe(1'b0);
        wd_measure(5000, r);
        check("R9 full period after clear", r, 1024);

        // R10 enable low holds the count
        write_ctl(8'h02);
        wd_strobe(1'b0);
        wd_measure(100, r);
        wd_en = 1'b0;
        wd_measure(400, r);
        check("R10 no timeout while disabled", r, 0);
        wd_en = 1'b1;
        wd_measure(5000, r);
        check("R10 resumes from held count", r, 156);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule